// File: doc/BRIEF.md
# Asynchronous Handshake Byte Sender (Target Side)

This block is the sending half of a target device's data phase on a parallel bus that carries eight data lines, one parity line and a REQ/ACK handshake. Upstream logic loads a transfer length in words and then supplies 32-bit words over a valid/ready interface. The block cuts each word into four bytes, drives each byte with its odd parity onto the active-low bus together with REQ, and completes one full four-edge REQ/ACK exchange per byte before moving on.

If the upstream buffer has not yet produced the next word, the block waits with REQ released and accepts the word as soon as it appears, so it can follow a buffer that is still filling. A bus-reset input cancels the transfer at any point and releases the bus. On normal completion all data lines, parity and REQ go back to their released level, a one-cycle done pulse is given, and a byte counter shows how many bytes finished their handshake.

Top module: `async_tgt_sender`

## Requirements
- R1: The bytes of each accepted word are sent least significant first: bits 7:0, then 15:8, then 23:16, then 31:24.
- R2: The parity line carries odd parity: the parity bit is 1 XOR the XOR of the eight data bits, so the nine asserted bits always hold an odd number of ones.
- R3: All bus outputs are active low: a data or parity bit of 1 drives its line to 0 and a bit of 0 leaves the line at 1; `db_n[i]` carries data bit i.
- R4: Data and parity change in the same cycle that REQ goes low (0), and stay unchanged for as long as REQ stays low.
- R5: ACK is active low on `ack_n` and passes through a two-flop synchroniser. REQ is raised only after the synchronised ACK is seen active, and the next byte is not presented until the synchronised ACK is seen inactive again.
- R6: While `bus_rst` is 1 in a busy cycle, the next cycle has REQ, data and parity released, `busy` low and no done pulse; a word offered in that same cycle is consumed and dropped.
- R7: `in_ready` is 1 only while the block waits for a word; with `in_valid` low it waits with REQ released and sends nothing.
- R8: After the final byte's ACK goes inactive, the lines and REQ are released, `done` pulses for one cycle and `byte_count` equals four times the requested word count.
- R9: A `start` with `word_count` of 0 gives a done pulse in the next cycle and never asserts REQ.
- R10: `start` is ignored while a transfer is in progress (`busy` high); `busy` is 1 from the cycle after an accepted start until the transfer ends.
- R11: After reset, all bus outputs are released (1), `busy`, `done` and `in_ready` are 0 and `byte_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transfer when idle |
| word_count | input | CNT_W | Number of words in the transfer, sampled with start |
| in_data | input | LANES*BYTE_W | Word from the upstream buffer |
| in_valid | input | 1 | Upstream word available |
| in_ready | output | 1 | Block is waiting for a word |
| ack_n | input | 1 | Bus ACK from the initiator, active low, asynchronous |
| bus_rst | input | 1 | Bus reset seen, active high, synchronous to clk |
| db_n | output | BYTE_W | Data lines, active low |
| dbp_n | output | 1 | Parity line, active low |
| req_n | output | 1 | Bus REQ, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| byte_count | output | CNT_W+log2(LANES) | Bytes handshaken in the current or last transfer |

## Verification
The two functions that can meet in one cycle are the bus-reset abort and the acceptance of a new word from the upstream buffer. The bench holds the buffer empty so the block sits waiting for a word, then releases the word and raises `bus_rst` for the very cycle in which `in_valid` and `in_ready` are both high. The behavioural model consumes the word and goes idle in that cycle, and the outputs are compared every clock: REQ must never fall, the lines must stay released and no done pulse may follow.

// File: rtl/sab_pkg.sv
// Shared types and helpers for the asynchronous target byte sender.
// Assumes nothing beyond a synthesizable 2017 flow.
package sab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOAD     = 2'd1,
        ST_WAIT_ON  = 2'd2,
        ST_WAIT_OFF = 2'd3
    } sab_state_t;

endpackage

// File: rtl/sab_ack_sync.sv
// Multi-flop synchroniser for the asynchronous ACK level.
// Assumes the input is a slow level (a handshake line), not a pulse.
module sab_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture (only for tests with synchronous ACK)
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_multi
            // Shift the ACK level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sab_lane_encoder.sv
// Selects one byte lane of a word and forms the active-low bus image
// (data lines plus odd parity). Purely combinational.
// Assumes lane is below LANES.
module sab_lane_encoder #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [BYTE_W-1:0] lines_n,
    output logic              par_n
);

    logic [BYTE_W-1:0] lane_bytes [LANES];
    logic [BYTE_W-1:0] picked;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_bytes[g] = word[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    // Pick the requested lane, odd parity, invert for the bus
    always_comb begin
        picked  = lane_bytes[lane];
        lines_n = ~picked;
        par_n   = ~(1'b1 ^ (^picked));
    end

endmodule

// File: rtl/sab_tally.sv
// Remaining-word and completed-byte bookkeeping for one transfer.
// Assumes load is only raised with a non-zero count while idle.
module sab_tally #(
    parameter int CNT_W   = 16,
    parameter int BYTES_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_count,
    input  logic               byte_done,
    input  logic               word_done,
    output logic               last_word,
    output logic [BYTES_W-1:0] byte_count
);

    logic [CNT_W-1:0] remaining;

    // Words still owed in this transfer
    always_ff @(posedge clk) begin
        if (!rst_n)         remaining <= '0;
        else if (load)      remaining <= load_count;
        else if (word_done) remaining <= remaining - 1'b1;
    end

    // Bytes whose handshake has completed
    always_ff @(posedge clk) begin
        if (!rst_n)         byte_count <= '0;
        else if (load)      byte_count <= '0;
        else if (byte_done) byte_count <= byte_count + 1'b1;
    end

    assign last_word = (remaining == CNT_W'(1));

endmodule

// File: rtl/async_tgt_sender.sv
// Target-side byte sender for an asynchronous REQ/ACK data phase.
// Takes words over valid/ready, sends them low byte first with odd
// parity on active-low lines, one full handshake per byte.
// Assumes bus_rst is already synchronous to clk; ack_n may be async.
module async_tgt_sender
    import sab_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int BYTE_W      = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W  = LANES * BYTE_W,
    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int BYTES_W = CNT_W + LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   word_count,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               ack_n,
    input  logic               bus_rst,
    output logic [BYTE_W-1:0]  db_n,
    output logic               dbp_n,
    output logic               req_n,
    output logic               busy,
    output logic               done,
    output logic [BYTES_W-1:0] byte_count
);

    sab_state_t        state;
    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic              ack_s;
    logic              last_word;
    logic              tally_load;
    logic              byte_done;
    logic              word_done;
    logic [WORD_W-1:0] enc_word;
    logic [LANE_W-1:0] enc_lane;
    logic [BYTE_W-1:0] enc_lines_n;
    logic              enc_par_n;
    logic              last_lane;

    sab_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (~ack_n),
        .sync_out (ack_s)
    );

    sab_lane_encoder #(.LANES(LANES), .BYTE_W(BYTE_W)) u_enc (
        .word    (enc_word),
        .lane    (enc_lane),
        .lines_n (enc_lines_n),
        .par_n   (enc_par_n)
    );

    sab_tally #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tally_load),
        .load_count (word_count),
        .byte_done  (byte_done),
        .word_done  (word_done),
        .last_word  (last_word),
        .byte_count (byte_count)
    );

    // Choose what the encoder looks at: fresh word or next lane of held word
    always_comb begin
        last_lane = (lane_q == LANE_W'(LANES - 1));
        if (state == ST_LOAD) begin
            enc_word = in_data;
            enc_lane = '0;
        end else begin
            enc_word = word_q;
            enc_lane = LANE_W'(lane_q + 1'b1);
        end
    end

    // Control strobes for the tally
    always_comb begin
        tally_load = (state == ST_IDLE) && start && !bus_rst && (word_count != '0);
        byte_done  = (state == ST_WAIT_OFF) && !ack_s && !bus_rst;
        word_done  = byte_done && last_lane;
    end

    assign in_ready = (state == ST_LOAD);
    assign busy     = (state != ST_IDLE);

    // Handshake sequencer and registered bus image
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            word_q <= '0;
            lane_q <= '0;
            db_n   <= '1;
            dbp_n  <= 1'b1;
            req_n  <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state != ST_IDLE && bus_rst) begin
                state <= ST_IDLE;
                db_n  <= '1;
                dbp_n <= 1'b1;
                req_n <= 1'b1;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start && !bus_rst) begin
                            if (word_count == '0) done  <= 1'b1;
                            else                  state <= ST_LOAD;
                        end
                    end
                    ST_LOAD: begin
                        if (in_valid) begin
                            word_q <= in_data;
                            lane_q <= '0;
                            db_n   <= enc_lines_n;
                            dbp_n  <= enc_par_n;
                            req_n  <= 1'b0;
                            state  <= ST_WAIT_ON;
                        end
                    end
                    ST_WAIT_ON: begin
                        if (ack_s) begin
                            req_n <= 1'b1;
                            state <= ST_WAIT_OFF;
                        end
                    end
                    ST_WAIT_OFF: begin
                        if (!ack_s) begin
                            if (!last_lane) begin
                                lane_q <= LANE_W'(lane_q + 1'b1);
                                db_n   <= enc_lines_n;
                                dbp_n  <= enc_par_n;
                                req_n  <= 1'b0;
                                state  <= ST_WAIT_ON;
                            end else if (last_word) begin
                                db_n  <= '1;
                                dbp_n <= 1'b1;
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_LOAD;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_n |-> (^{~db_n, ~dbp_n}) == 1'b1); // R2

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && !$past(req_n)) |-> ($stable(db_n) && $stable(dbp_n))); // R4

    AST_REQ_RISE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_n) && !$past(bus_rst)) |-> $past(ack_s)); // R5

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rst) |-> (req_n && (&db_n) && dbp_n && !busy && !done)); // R6

    AST_READY_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> req_n); // R7

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_n && (&db_n) && dbp_n && !busy)); // R8

endmodule

// File: tb/sim_async_tgt_sender.sv
module sim_async_tgt_sender;

    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int BW     = CNT_W + 2;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   word_count = '0;
    logic [31:0]   in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          ack_n = 1'b1;
    logic          bus_rst = 1'b0;
    logic [7:0]    db_n;
    logic          dbp_n;
    logic          req_n;
    logic          busy;
    logic          done;
    logic [BW-1:0] byte_count;

    async_tgt_sender #(.LANES(LANES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .ack_n(ack_n), .bus_rst(bus_rst), .db_n(db_n), .dbp_n(dbp_n),
        .req_n(req_n), .busy(busy), .done(done), .byte_count(byte_count)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit live = 0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // ---------------- upstream buffer and expected bytes ----------------
    logic [31:0] wq[$];
    logic [7:0]  eb[$];
    bit hold_feed = 0;
    bit gap_mode  = 0;

    task automatic push_word(input logic [31:0] w);
        wq.push_back(w);
        for (int i = 0; i < 4; i++) eb.push_back(w[8*i +: 8]);
    endtask

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (hold_feed || wq.size() == 0 || (gap_mode && (cyc % 3) != 0)) begin
            in_valid = 1'b0;
            in_data  = 32'hA5A5_5A5A;
        end else begin
            in_valid = 1'b1;
            in_data  = wq[0];
        end
    end

    // ---------------- initiator responder ----------------
    int ack_dly = 1;
    int rel_dly = 1;
    int rcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ack_n = 1'b1;
            rcnt  = 0;
        end else if (ack_n) begin
            if (!req_n) begin
                if (rcnt >= ack_dly) begin ack_n = 1'b0; rcnt = 0; end
                else rcnt++;
            end else rcnt = 0;
        end else begin
            if (req_n) begin
                if (rcnt >= rel_dly) begin ack_n = 1'b1; rcnt = 0; end
                else rcnt++;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    int          ms = 0;      // 0 idle, 1 wait word, 2 wait ack on, 3 wait ack off
    int          mrem = 0;
    int          mbytes = 0;
    int          mlane = 0;
    logic [31:0] mword = '0;
    logic [7:0]  m_db_n = 8'hFF;
    logic        m_dbp_n = 1'b1;
    logic        m_req_n = 1'b1;
    logic        m_done = 1'b0;
    logic        ack_old = 1'b0, ack_new = 1'b0;

    function automatic logic odd_par(input logic [7:0] b);
        int ones = 0;
        for (int i = 0; i < 8; i++) if (b[i]) ones++;
        return (ones % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic m_present();
        logic [7:0] b;
        b = mword[8*mlane +: 8];
        m_db_n  = ~b;
        m_dbp_n = ~odd_par(b);
        m_req_n = 1'b0;
    endtask

    task automatic m_release();
        m_db_n  = 8'hFF;
        m_dbp_n = 1'b1;
        m_req_n = 1'b1;
    endtask

    always @(posedge clk) begin
        logic ack_seen;
        cyc++;
        if (!rst_n) begin
            ms = 0; mrem = 0; mbytes = 0; mlane = 0; mword = '0;
            m_release(); m_done = 1'b0; ack_old = 1'b0; ack_new = 1'b0;
        end else begin
            ack_seen = ack_old;
            ack_old  = ack_new;
            ack_new  = ~ack_n;
            m_done   = 1'b0;
            if (ms == 1 && in_valid) void'(wq.pop_front());
            if (ms != 0 && bus_rst) begin
                ms = 0;
                m_release();
            end else begin
                case (ms)
                    0: if (start && !bus_rst) begin
                           if (word_count == 0) m_done = 1'b1;
                           else begin mrem = word_count; mbytes = 0; ms = 1; end
                       end
                    1: if (in_valid) begin
                           mword = in_data; mlane = 0; m_present(); ms = 2;
                       end
                    2: if (ack_seen) begin m_req_n = 1'b1; ms = 3; end
                    default: if (!ack_seen) begin
                           mbytes++;
                           if (mlane < 3) begin mlane++; m_present(); ms = 2; end
                           else if (mrem == 1) begin m_release(); m_done = 1'b1; ms = 0; end
                           else begin mrem--; ms = 1; end
                       end
                endcase
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    logic       prev_req_n = 1'b1;
    logic [7:0] prev_db_n  = 8'hFF;
    logic       prev_dbp_n = 1'b1;
    always @(negedge clk) begin
        if (live) begin
            chk("R3",  "db_n",       {56'd0, db_n},       {56'd0, m_db_n});
            chk("R2",  "dbp_n",      {63'd0, dbp_n},      {63'd0, m_dbp_n});
            chk("R5",  "req_n",      {63'd0, req_n},      {63'd0, m_req_n});
            chk("R8",  "done",       {63'd0, done},       {63'd0, m_done});
            chk("R8",  "byte_count", 64'(byte_count),     64'(mbytes));
            chk("R7",  "in_ready",   {63'd0, in_ready},   {63'd0, (ms == 1)});
            chk("R10", "busy",       {63'd0, busy},       {63'd0, (ms != 0)});
            if (!req_n) chk("R2", "odd ones on bus", {63'd0, ^{~db_n, ~dbp_n}}, 64'd1);
            if (!req_n && !prev_req_n)
                chk("R4", "data held under REQ", {55'd0, db_n, dbp_n}, {55'd0, prev_db_n, prev_dbp_n});
            if (!req_n && prev_req_n) begin
                if (eb.size() > 0) chk("R1", "byte order", {56'd0, ~db_n}, {56'd0, eb.pop_front()});
                else               chk("R1", "unexpected byte", 64'd1, 64'd0);
            end
        end
        prev_req_n = req_n;
        prev_db_n  = db_n;
        prev_dbp_n = dbp_n;
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 100000) begin
            miscompares++;
            $display("FAIL watchdog run did not finish");
            finish_run();
        end
    end

    task automatic start_xfer(input int n);
        @(negedge clk);
        start = 1'b1;
        word_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        live = 1;
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "req_n after reset", {63'd0, req_n}, 64'd1);
        chk("R11", "db_n after reset", {56'd0, db_n}, 64'hFF);
        chk("R11", "busy after reset", {63'd0, busy}, 64'd0);
        chk("R11", "byte_count after reset", 64'(byte_count), 64'd0);

        // single word, mixed bytes (R1 R3)
        push_word(32'h8001_FF00);
        start_xfer(1);
        wait_done();
        chk("R8", "bytes after one word", 64'(byte_count), 64'd4);
        chk("R8", "lines released at done", {54'd0, req_n, db_n, dbp_n}, {54'd0, 1'b1, 8'hFF, 1'b1});

        // three words, gappy buffer, slower initiator, start while busy (R7 R10)
        gap_mode = 1; ack_dly = 3; rel_dly = 2;
        push_word(32'h1234_5678);
        push_word(32'hA5C3_0F96);
        push_word(32'h0000_0001);
        start_xfer(3);
        repeat (20) @(negedge clk);
        start = 1'b1; word_count = 16'd5;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R10", "start while busy ignored", 64'(byte_count), 64'd12);
        gap_mode = 0; ack_dly = 1; rel_dly = 1;

        // zero-length transfer (R9)
        start_xfer(0);
        chk("R9", "done for zero count", {63'd0, done}, 64'd1);
        chk("R9", "no REQ for zero count", {63'd0, req_n}, 64'd1);
        repeat (3) @(negedge clk);

        // abort while waiting for ACK (R6)
        ack_dly = 40;
        push_word(32'hDEAD_BEEF);
        push_word(32'h0BAD_F00D);
        start_xfer(2);
        do @(negedge clk); while (req_n);
        repeat (3) @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        chk("R6", "REQ released on abort", {63'd0, req_n}, 64'd1);
        chk("R6", "lines released on abort", {56'd0, db_n}, 64'hFF);
        chk("R6", "idle after abort", {63'd0, busy}, 64'd0);
        wq.delete(); eb.delete();
        ack_dly = 1;
        repeat (6) @(negedge clk);

        // abort in the same cycle a word is accepted (R6)
        hold_feed = 1;
        push_word(32'h0F0F_0F0F);
        start_xfer(1);
        repeat (2) @(negedge clk);
        hold_feed = 0;
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        chk("R6", "no REQ after coincident abort", {63'd0, req_n}, 64'd1);
        chk("R6", "idle after coincident abort", {63'd0, busy}, 64'd0);
        repeat (3) @(negedge clk);
        chk("R6", "no done after abort", {63'd0, done}, 64'd0);
        wq.delete(); eb.delete();

        // parity corners: all ones and all zeros (R2 R8)
        push_word(32'hFFFF_FFFF);
        push_word(32'h0000_0000);
        start_xfer(2);
        wait_done();
        chk("R8", "bytes after two words", 64'(byte_count), 64'd8);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule